// File: doc/BRIEF.md
# PCIe Enhanced Configuration Window Decoder

This block owns the 64-bit base register of a memory-mapped PCI Express configuration window. Software writes the register through a byte-enabled write port. The block turns the stored value into three things: an enable flag, a window size, and a base address aligned to that size. Every physical address presented on the lookup port is compared against the window. The block reports whether the address hits the window. On a hit it also splits the offset into bus, device, function and register-offset fields, so that a configuration engine behind it can use them.

The window size is chosen by a two-bit code. A smaller window makes more base-address bits significant, and the register's low base bits are ignored to match the size. The fourth size code is not a legal setting. It raises an error flag that stays set until reset, and the window stays closed while that code is in force. Any write that touches any byte of the register causes the decode to be recomputed. The new decode is in force from the clock edge after the write edge.

Top module: `ecam_win_decoder`

## Requirements
- R1: After reset the register reads 0x00000000_B0000001: window enabled, size code 00 (256 MB), base 0xB0000000, error flag low.
- R2: A write changes exactly the register bytes whose byte-enable bit is set (byte i is bits [8i+7:8i]). A write with all enables low, or with wr_en low, leaves the register unchanged.
- R3: Register bit 0 is the window enable. While it is 0, hit stays low for every address.
- R4: Register bits [2:1] select the window size: 00 = 256 MB, 01 = 128 MB, 10 = 64 MB. An address hits exactly when it lies in [base, base + size).
- R5: The base is the register ANDed with a size-dependent mask. The mask covers address bits [38:28] for 256 MB, adds bit 27 for 128 MB, and adds bits 27 and 26 for 64 MB. Register bits below the mask have no effect on the base.
- R6: Size code 11 forces hit low and sets cfg_err. cfg_err stays set through later writes until reset.
- R7: On a hit, the offset from the base gives bus = offset[27:20], dev = offset[19:15], fn = offset[14:12] and reg_off = offset[11:0]. Bus bits above the window size read 0. On a miss, all four fields are 0.
- R8: A write completing at clock edge N leaves the previous decode in force until edge N+1. The new decode applies from edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 8 | Byte enables for the write |
| wr_data | input | 64 | Write data |
| cfg_value | output | 64 | Current register contents |
| req_addr | input | 39 | Physical address to look up |
| win_en | output | 1 | Decoded window enable |
| win_len | output | 2 | Decoded size code |
| win_base | output | 39 | Decoded, size-aligned window base |
| cfg_err | output | 1 | Sticky reserved-size error |
| hit | output | 1 | req_addr lies inside the active window |
| bus | output | 8 | Bus number field of the offset |
| dev | output | 5 | Device field of the offset |
| fn | output | 3 | Function field of the offset |
| reg_off | output | 12 | Register offset field |

## Verification
The hardest behaviour to reach from the ports is the one-edge lag between a register write and the decode that uses it. It can only be seen by sampling hit in the single cycle between the write edge and the following edge. The bench opens that cycle on purpose: it disables an active window and checks hit at the negative edge right after the write, then one cycle later. Window boundaries are tested one byte inside and one byte outside for every size. A register value with stray low base bits shows that those bits are masked away.

// File: rtl/ecam_pkg.sv
package ecam_pkg;

    localparam int REG_W      = 64;
    localparam int REG_BYTES  = REG_W / 8;
    localparam int WIN_LSB    = 28;   // lowest base bit of the largest window
    localparam int EN_BIT     = 0;
    localparam int LEN_LSB    = 1;

    typedef enum logic [1:0] {
        LEN_256M = 2'b00,
        LEN_128M = 2'b01,
        LEN_64M  = 2'b10,
        LEN_RSVD = 2'b11
    } win_len_e;

    typedef struct packed {
        logic             en;
        win_len_e         len;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] base;
    } win_dec_t;

    function automatic win_dec_t decode_bar(input logic [REG_W-1:0] bar, input int addr_w);
        win_dec_t r;
        r.en   = bar[EN_BIT];
        r.len  = win_len_e'(bar[LEN_LSB +: 2]);
        r.mask = '0;
        for (int b = WIN_LSB; b < REG_W; b++) begin
            if (b < addr_w) r.mask[b] = 1'b1;
        end
        case (r.len)
            LEN_128M: r.mask[WIN_LSB-1] = 1'b1;
            LEN_64M: begin
                r.mask[WIN_LSB-1] = 1'b1;
                r.mask[WIN_LSB-2] = 1'b1;
            end
            default: ;
        endcase
        r.base = bar & r.mask;
        return r;
    endfunction

endpackage

// File: rtl/ecam_bar_reg.sv
module ecam_bar_reg
    import ecam_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_VAL = 64'h0000_0000_B000_0001
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_BYTES-1:0] wr_be,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     bar_q,
    output logic                 upd_q
);

    typedef struct packed {
        logic [REG_W-1:0] bar;
        logic             upd;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [REG_W-1:0] merged;

    for (genvar i = 0; i < REG_BYTES; i++) begin : g_byte
        assign merged[i*8 +: 8] = (wr_en && wr_be[i]) ? wr_data[i*8 +: 8]
                                                      : st_q.bar[i*8 +: 8];
    end

    always_comb begin
        st_d     = st_q;
        st_d.bar = merged;
        st_d.upd = wr_en && (|wr_be);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bar <= RESET_VAL;
            st_q.upd <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bar_q = st_q.bar;
    assign upd_q = st_q.upd;

endmodule

// File: rtl/ecam_bar_decode.sv
module ecam_bar_decode
    import ecam_pkg::*;
#(
    parameter int               ADDR_W    = 39,
    parameter logic [REG_W-1:0] RESET_VAL = 64'h0000_0000_B000_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] bar,
    input  logic             upd,
    output win_dec_t         dec_q,
    output logic             err_q
);

    typedef struct packed {
        win_dec_t dec;
        logic     err;
    } dec_st_t;

    dec_st_t st_d, st_q;
    win_dec_t fresh;

    always_comb begin
        fresh = decode_bar(bar, ADDR_W);
        st_d  = st_q;
        if (upd) begin
            st_d.dec = fresh;
            st_d.err = st_q.err | (fresh.len == LEN_RSVD);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dec <= decode_bar(RESET_VAL, ADDR_W);
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_q = st_q.dec;
    assign err_q = st_q.err;

endmodule

// File: rtl/ecam_addr_match.sv
module ecam_addr_match
    import ecam_pkg::*;
#(
    parameter int ADDR_W = 39
) (
    input  win_dec_t          dec,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [7:0]        bus,
    output logic [4:0]        dev,
    output logic [2:0]        fn,
    output logic [11:0]       reg_off
);

    logic [ADDR_W-1:0]  mask_a;
    logic [ADDR_W-1:0]  base_a;
    logic [WIN_LSB-1:0] offs;

    always_comb begin
        mask_a  = dec.mask[ADDR_W-1:0];
        base_a  = dec.base[ADDR_W-1:0];
        hit     = dec.en && (dec.len != LEN_RSVD) && ((addr & mask_a) == base_a);
        offs    = addr[WIN_LSB-1:0] & ~mask_a[WIN_LSB-1:0];
        if (!hit) offs = '0;
        bus     = offs[27:20];
        dev     = offs[19:15];
        fn      = offs[14:12];
        reg_off = offs[11:0];
    end

endmodule

// File: rtl/ecam_win_decoder.sv
module ecam_win_decoder
    import ecam_pkg::*;
#(
    parameter int               ADDR_W    = 39,
    parameter logic [REG_W-1:0] RESET_VAL = 64'h0000_0000_B000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_be,
    input  logic [63:0]       wr_data,
    output logic [63:0]       cfg_value,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              win_en,
    output logic [1:0]        win_len,
    output logic [ADDR_W-1:0] win_base,
    output logic              cfg_err,
    output logic              hit,
    output logic [7:0]        bus,
    output logic [4:0]        dev,
    output logic [2:0]        fn,
    output logic [11:0]       reg_off
);

    logic     upd;
    win_dec_t dec;

    ecam_bar_reg #(.RESET_VAL(RESET_VAL)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .bar_q(cfg_value), .upd_q(upd)
    );

    ecam_bar_decode #(.ADDR_W(ADDR_W), .RESET_VAL(RESET_VAL)) u_dec (
        .clk(clk), .rst_n(rst_n), .bar(cfg_value), .upd(upd),
        .dec_q(dec), .err_q(cfg_err)
    );

    ecam_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .dec(dec), .addr(req_addr), .hit(hit), .bus(bus),
        .dev(dev), .fn(fn), .reg_off(reg_off)
    );

    assign win_en   = dec.en;
    assign win_len  = dec.len;
    assign win_base = dec.base[ADDR_W-1:0];

endmodule

// File: rtl/ecam_win_chk.sv
module ecam_win_chk #(
    parameter int ADDR_W = 39
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [7:0]  wr_be,
    input logic [63:0] cfg_value,
    input logic        win_en,
    input logic [1:0]  win_len,
    input logic        cfg_err,
    input logic        hit,
    input logic [7:0]  bus,
    input logic [4:0]  dev,
    input logic [2:0]  fn,
    input logic [11:0] reg_off
);

    AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> !hit); // R3
    AST_RSVD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (win_len == 2'b11) |-> !hit); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R6
    AST_IDLE_HOLDS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (|wr_be)) |=> $stable(cfg_value)); // R2
    AST_NARROW_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && win_len == 2'b10) |-> (bus[7:6] == 2'b00)); // R7
    AST_MISS_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> ({bus, dev, fn, reg_off} == '0)); // R7

endmodule

bind ecam_win_decoder ecam_win_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .cfg_value(cfg_value), .win_en(win_en), .win_len(win_len),
    .cfg_err(cfg_err), .hit(hit), .bus(bus), .dev(dev), .fn(fn),
    .reg_off(reg_off)
);

// File: tb/ecam_win_decoder_test.sv
module ecam_win_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 39;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_be = '0;
    logic [63:0]   wr_data = '0;
    logic [63:0]   cfg_value;
    logic [AW-1:0] req_addr = '0;
    logic          win_en, cfg_err, hit;
    logic [1:0]    win_len;
    logic [AW-1:0] win_base;
    logic [7:0]    bus;
    logic [4:0]    dev;
    logic [2:0]    fn;
    logic [11:0]   reg_off;

    int checks = 0;
    int fails  = 0;
    logic [63:0] dec_reg;   // register value the decode should be using
    logic [63:0] exp_reg;   // expected register contents

    always #(CLK_PERIOD/2) clk = ~clk;

    ecam_win_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .cfg_value(cfg_value), .req_addr(req_addr), .win_en(win_en), .win_len(win_len),
        .win_base(win_base), .cfg_err(cfg_err), .hit(hit), .bus(bus), .dev(dev),
        .fn(fn), .reg_off(reg_off)
    );

    function automatic logic [63:0] m_size(input logic [63:0] r);
        return 64'd1 << (28 - int'(r[2:1]));
    endfunction

    function automatic logic [63:0] m_base(input logic [63:0] r);
        return {25'd0, r[38:0]} & ~(m_size(r) - 64'd1);
    endfunction

    function automatic logic m_hit(input logic [63:0] r, input logic [63:0] a);
        return r[0] && (r[2:1] != 2'b11) && (a >= m_base(r)) && (a < m_base(r) + m_size(r));
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic [63:0] a);
        logic [63:0] off;
        logic        eh;
        req_addr = a[AW-1:0];
        #1;
        eh  = m_hit(dec_reg, a);
        off = eh ? (a - m_base(dec_reg)) : 64'd0;
        check({req, " hit"}, {63'd0, hit}, {63'd0, eh});
        check({req, " fields"}, {36'd0, bus, dev, fn, reg_off}, {36'd0, off[27:0]});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n   = 1'b1;
        exp_reg = 64'h0000_0000_B000_0001;
        dec_reg = exp_reg;
    endtask

    // drive one write; returns at the negedge right after the write edge
    task automatic write_raw(input logic [7:0] be, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        for (int i = 0; i < 8; i++) if (be[i]) exp_reg[i*8 +: 8] = d[i*8 +: 8];
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0;
    endtask

    task automatic write_full(input logic [7:0] be, input logic [63:0] d);
        write_raw(be, d);
        @(negedge clk);
        dec_reg = exp_reg;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1 value", cfg_value, 64'h0000_0000_B000_0001);
        check("R1 en", {63'd0, win_en}, 64'd1);
        check("R1 len", {62'd0, win_len}, 64'd0);
        check("R1 base", {25'd0, win_base}, 64'hB000_0000);
        check("R1 err", {63'd0, cfg_err}, 64'd0);
        probe("R1 R4 low edge", 64'hB000_0000);
        probe("R4 top", 64'hBFFF_FFFF);
        probe("R4 above", 64'hC000_0000);
        probe("R4 below", 64'hAFFF_FFFF);
        probe("R7 split", 64'hB0A5_B123);
    endtask

    task automatic t_bytes();
        write_full(8'b0000_0010, 64'hFFFF_FFFF_FFFF_FFFF);
        #1; check("R2 one byte", cfg_value, exp_reg);
        write_full(8'b0000_0000, 64'h1234_5678_9ABC_DEF0);
        #1; check("R2 no enables", cfg_value, exp_reg);
        @(negedge clk);
        wr_en = 1'b0; wr_be = 8'hFF; wr_data = 64'h5555_5555_5555_5555;
        @(negedge clk); wr_be = '0;
        #1; check("R2 strobe low", cfg_value, exp_reg);
        write_full(8'hFF, 64'h0000_0000_B000_0001);
        #1; check("R2 full", cfg_value, 64'h0000_0000_B000_0001);
    endtask

    task automatic t_sizes();
        write_full(8'hFF, 64'h0000_0000_E800_0003);
        #1; check("R5 base128", {25'd0, win_base}, 64'hE800_0000);
        probe("R4 128 low", 64'hE800_0000);
        probe("R4 128 top", 64'hEFFF_FFFF);
        probe("R4 128 above", 64'hF000_0000);
        probe("R4 128 below", 64'hE7FF_FFFF);
        probe("R7 128 bus", 64'hEFF1_8004);
        write_full(8'hFF, 64'h0000_0000_EC00_0005);
        #1; check("R5 base64", {25'd0, win_base}, 64'hEC00_0000);
        probe("R4 64 low", 64'hEC00_0000);
        probe("R4 64 top", 64'hEFFF_FFFF);
        probe("R4 64 below", 64'hEBFF_FFFF);
        probe("R5 high bit", 64'h40_EC00_0000);
        probe("R7 64 bus", 64'hEFEF_F7FF);
        write_full(8'hFF, 64'h0000_0000_D800_0001);
        #1; check("R5 stray bit", {25'd0, win_base}, 64'hD000_0000);
        probe("R5 256 low", 64'hD000_0000);
        probe("R5 256 mid", 64'hD7FF_FFFF);
    endtask

    task automatic t_disable();
        write_full(8'hFF, 64'h0000_0000_9000_0000);
        probe("R3 disabled", 64'h9000_0000);
        probe("R3 disabled mid", 64'h9123_4567);
    endtask

    task automatic t_latency();
        write_full(8'hFF, 64'h0000_0000_9000_0001);
        probe("R8 on", 64'h9000_1000);
        write_raw(8'h01, 64'h0000_0000_0000_0000);
        probe("R8 old decode", 64'h9000_1000);
        @(negedge clk);
        dec_reg = exp_reg;
        probe("R8 new decode", 64'h9000_1000);
    endtask

    task automatic t_reserved();
        write_full(8'hFF, 64'h0000_0000_B000_0007);
        #1; check("R6 err set", {63'd0, cfg_err}, 64'd1);
        probe("R6 no hit", 64'hB000_0000);
        write_full(8'hFF, 64'h0000_0000_B000_0001);
        #1; check("R6 err sticky", {63'd0, cfg_err}, 64'd1);
        probe("R6 valid again", 64'hB000_0000);
        do_reset();
        #1; check("R6 R1 err cleared", {63'd0, cfg_err}, 64'd0);
    endtask

    bit done = 1'b0;

    initial begin
        exp_reg = 64'h0000_0000_B000_0001;
        dec_reg = exp_reg;
        t_reset();
        t_bytes();
        t_sizes();
        t_disable();
        t_latency();
        t_reserved();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule